// File: doc/BRIEF.md
# Programmable Asynchronous Character Transmitter

This block turns bytes written by a host into framed asynchronous serial characters. The host writes one byte into a holding register. As soon as the shift stage is free and sending is allowed, the byte moves into the shift stage on its own. While that character goes out, the host can already write the next one. Each frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one, one and a half or two high stop bits. Between frames the line stays high.

The whole block runs on one system clock. Serial timing comes from two single-cycle strobes: `txc_fall` marks a falling edge of the transmit clock and `txc_rise` marks a rising edge. Character length, parity, stop length and the clock divisor (one, sixteen or sixty-four strobes per bit) are plain configuration inputs. They are captured when a character starts.

Two status outputs report the state of the buffers. `tx_rdy` means the host may write. `tx_empty` means nothing is held and nothing is being shifted. A clear-to-send input (active low) and a transmit-enable input stop new characters from starting, but never cut off a character already on the line.

Top module: `async_char_tx`

## Requirements
- R1: After synchronous reset `txd` is 1, `tx_empty` is 1, and `tx_rdy` follows R8 with an empty holding register.
- R2: A frame is one 0 start bit, then the data bits with the least significant bit first, then any parity bit, then the stop bits at 1. Outside frames `txd` is 1.
- R3: `cfg_len` selects the character length: 00=5, 01=6, 10=7, 11=8 bits. Only that many low bits of the written byte are sent, and the higher bits have no effect on the line.
- R4: When `cfg_par_en`=1, one parity bit follows the last data bit. It is computed over the sent data bits only. `cfg_par_even`=1 makes the count of ones in data plus parity even; 0 makes it odd. When `cfg_par_en`=0 no parity bit is sent.
- R5: `cfg_stop` selects the stop length: 00 or 01 = one bit, 11 = two bits, 10 = one and a half bits. With ×1, the half bit ends at the first `txc_rise` after the final full stop bit. With ×16 or ×64, the half bit lasts 8 or 32 `txc_fall` strobes.
- R6: `cfg_div` selects strobes per bit: 00 or 01 = ×1, 10 = ×16, 11 = ×64. The start bit appears on `txd` in the cycle after the `txc_fall` strobe that starts the character. Each bit then lasts exactly that many `txc_fall` strobes.
- R7: A held byte enters the shift stage at a `txc_fall` strobe when the shift stage is idle or finishing its frame on that same strobe. A byte written during a frame therefore starts on the strobe that ends the previous frame, with no idle gap, and the holding register empties when the byte enters the shift stage.
- R8: `tx_rdy` is 1 exactly when the holding register is empty, `tx_en` is 1 and `cts_n` is 0. It is 0 in the cycle after a write.
- R9: `tx_empty` is 1 when both the holding register and the shift stage are empty. It is 0 in the cycle after a write.
- R10: While `cts_n` is 1 or `tx_en` is 0, no new character starts, and a character already started runs to its last stop bit. A held character starts at the first `txc_fall` after both conditions allow it again.
- R11: Configuration inputs are captured when a character starts. Changing them during a frame does not alter that frame.
- R12: `txd` changes only in the cycle after a `txc_fall` strobe; a `txc_rise` strobe never changes `txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txc_fall | input | 1 | One-cycle strobe for a falling transmit-clock edge |
| txc_rise | input | 1 | One-cycle strobe for a rising transmit-clock edge |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte written by the host |
| cfg_len | input | 2 | Character length select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | Parity sense, 1 = even |
| cfg_stop | input | 2 | Stop length select |
| cfg_div | input | 2 | Strobes-per-bit select |
| tx_en | input | 1 | Transmit enable command bit |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial data line |
| tx_rdy | output | 1 | Holding register may be written |
| tx_empty | output | 1 | Holding register and shift stage both empty |

## Verification
Suppose the bit-time counter holds a wrong count. The first visible effect is that a bit boundary on `txd` moves off its multiple of 1, 16 or 64 `txc_fall` strobes, and this shows within the bit in which the count went wrong. Suppose instead the prebuilt frame word is wrong, for example a bad length, parity or stop pattern. That shows as a wrong level on `txd` at the affected bit position, and no later than that frame's end, where `tx_empty` also rises too early or too late. A holding register that wrongly reads as full or empty shows in the very next cycle on `tx_rdy` or `tx_empty`, or as a missing or extra start bit at the next strobe that allows a start.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DATA_W  = 8;
  localparam int FRAME_W = 12;
  localparam int CNT_W   = 7;
  localparam int LEFT_W  = 4;

  // number of data bits for a length select
  function automatic int char_len(input logic [1:0] len_sel);
    return 5 + int'(len_sel);
  endfunction

  // parity over the sent data bits only
  function automatic logic parity_bit(input logic [DATA_W-1:0] d,
                                      input logic [1:0] len_sel,
                                      input logic even);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < char_len(len_sel)) acc = acc ^ d[i];
    return even ? acc : ~acc;
  endfunction

  function automatic logic [CNT_W-1:0] bit_ticks(input logic [1:0] div_sel);
    case (div_sel)
      2'b10:   return CNT_W'(16);
      2'b11:   return CNT_W'(64);
      default: return CNT_W'(1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] half_ticks(input logic [1:0] div_sel);
    case (div_sel)
      2'b10:   return CNT_W'(8);
      2'b11:   return CNT_W'(32);
      default: return CNT_W'(1);
    endcase
  endfunction

  // whole frame, bit 0 goes out first; unused positions are mark
  function automatic logic [FRAME_W-1:0] frame_word(input logic [DATA_W-1:0] d,
                                                    input logic [1:0] len_sel,
                                                    input logic par_en,
                                                    input logic even);
    logic [FRAME_W-1:0] f;
    int n;
    f    = '1;
    f[0] = 1'b0;
    n    = char_len(len_sel);
    for (int i = 0; i < DATA_W; i++)
      if (i < n) f[i+1] = d[i];
    if (par_en) f[n+1] = parity_bit(d, len_sel, even);
    return f;
  endfunction

  // count of full bit times in the frame (half stop excluded)
  function automatic logic [LEFT_W-1:0] frame_len(input logic [1:0] len_sel,
                                                  input logic par_en,
                                                  input logic two_stop);
    return LEFT_W'(1 + char_len(len_sel) + (par_en ? 1 : 0) + (two_stop ? 2 : 1));
  endfunction

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_full <= 1'b0;
    end else if (wr_en) begin
      hold_data <= wr_data;
      hold_full <= 1'b1;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  AST_TAKE_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    take |-> hold_full);                                            // R7
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> hold_full);                                           // R7

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer
  import sertx_pkg::*;
#(
  parameter int TW = CNT_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       run,
  input  logic       half_phase,
  input  logic       fall,
  input  logic       rise,
  input  logic [1:0] div_sel,
  output logic       tick_end
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim;
  logic          is_x1;
  logic          at_lim;

  assign lim      = half_phase ? TW'(half_ticks(div_sel)) : TW'(bit_ticks(div_sel));
  assign is_x1    = (bit_ticks(div_sel) == CNT_W'(1));
  assign at_lim   = (cnt_q == lim - TW'(1));
  assign tick_end = run & ((half_phase & is_x1) ? rise : (fall & at_lim));

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt_q <= '0;
    else if (run && fall)
      cnt_q <= at_lim ? '0 : cnt_q + TW'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < TW'(bit_ticks(div_sel))));                     // R6
  AST_TICK_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    tick_end |-> (fall || rise));                                   // R12

endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import sertx_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int LW = LEFT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] load_word,
  input  logic [LW-1:0] load_len,
  input  logic          load_half,
  input  logic          tick_end,
  output logic          busy,
  output logic          in_half,
  output logic          frame_done,
  output logic          txd
);

  logic [FW-1:0] frame_q;
  logic [LW-1:0] left_q;
  logic          half_q;
  logic          last_bit;

  assign last_bit   = (left_q == LW'(1));
  assign frame_done = busy & tick_end & (in_half | (last_bit & ~half_q));
  assign txd        = frame_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '1;
      left_q  <= '0;
      half_q  <= 1'b0;
      busy    <= 1'b0;
      in_half <= 1'b0;
    end else if (load) begin
      frame_q <= load_word;
      left_q  <= load_len;
      half_q  <= load_half;
      busy    <= 1'b1;
      in_half <= 1'b0;
    end else if (busy && tick_end) begin
      if (in_half) begin
        in_half <= 1'b0;
        busy    <= 1'b0;
      end else begin
        frame_q <= {1'b1, frame_q[FW-1:1]};
        left_q  <= left_q - LW'(1);
        if (last_bit) begin
          if (half_q) in_half <= 1'b1;
          else        busy    <= 1'b0;
        end
      end
    end
  end

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);                                                 // R2
  AST_START_BIT: assert property (@(posedge clk) disable iff (rst)
    load |=> !txd);                                                 // R2
  AST_HALF_MARK: assert property (@(posedge clk) disable iff (rst)
    in_half |-> txd);                                               // R5

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
  import sertx_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          txc_fall,
  input  logic          txc_rise,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_even,
  input  logic [1:0]    cfg_stop,
  input  logic [1:0]    cfg_div,
  input  logic          tx_en,
  input  logic          cts_n,
  output logic          txd,
  output logic          tx_rdy,
  output logic          tx_empty
);

  localparam int FW = FRAME_W;
  localparam int LW = LEFT_W;

  logic [DW-1:0] hold_data;
  logic          hold_full;
  logic          allow;
  logic          load;
  logic          busy;
  logic          in_half;
  logic          frame_done;
  logic          tick_end;
  logic [1:0]    div_q;
  logic [FW-1:0] word_n;
  logic [LW-1:0] len_n;

  assign allow    = tx_en & ~cts_n;
  assign load     = txc_fall & hold_full & allow & (~busy | frame_done);
  assign word_n   = frame_word(8'(hold_data), cfg_len, cfg_par_en, cfg_par_even);
  assign len_n    = frame_len(cfg_len, cfg_par_en, cfg_stop == 2'b11);
  assign tx_rdy   = ~hold_full & allow;
  assign tx_empty = ~hold_full & ~busy;

  always_ff @(posedge clk) begin
    if (rst)       div_q <= 2'b01;
    else if (load) div_q <= cfg_div;
  end

  tx_hold_buf #(.DATA_W(DW)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (load),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  tx_bit_timer #(.TW(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .restart    (load),
    .run        (busy),
    .half_phase (in_half),
    .fall       (txc_fall),
    .rise       (txc_rise),
    .div_sel    (div_q),
    .tick_end   (tick_end)
  );

  tx_frame_shifter #(.FW(FW), .LW(LW)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_word  (word_n),
    .load_len   (len_n),
    .load_half  (cfg_stop == 2'b10),
    .tick_end   (tick_end),
    .busy       (busy),
    .in_half    (in_half),
    .frame_done (frame_done),
    .txd        (txd)
  );

  AST_RDY_DROP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tx_rdy);                                             // R8
  AST_EMPTY_DROP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tx_empty);                                           // R9
  AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!busy && (!tx_en || cts_n)) |=> !busy);                        // R10
  AST_TXD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !txc_fall |=> $stable(txd));                                    // R12

endmodule

// File: tb/tb_async_char_tx.sv
module tb_async_char_tx;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       txc_fall, txc_rise, wr_en;
  logic [7:0] wr_data;
  logic [1:0] cfg_len, cfg_stop, cfg_div;
  logic       cfg_par_en, cfg_par_even, tx_en, cts_n;
  logic       txd, tx_rdy, tx_empty;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_char_tx dut (
    .clk(clk), .rst(rst), .txc_fall(txc_fall), .txc_rise(txc_rise),
    .wr_en(wr_en), .wr_data(wr_data), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop(cfg_stop), .cfg_div(cfg_div), .tx_en(tx_en), .cts_n(cts_n),
    .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
  );

  // {data[15:8], len[7:6], par_en[5], par_even[4], stop[3:2], div[1:0]}
  localparam logic [15:0] VEC [8] = '{
    16'h3539, 16'hA5C1, 16'hFF6D, 16'h5AB6,
    16'hC3EA, 16'h0F0F, 16'hE031, 16'h81AB
  };

  function automatic int n_data(input logic [1:0] l);
    case (l) 2'b00: return 5; 2'b01: return 6; 2'b10: return 7; default: return 8; endcase
  endfunction

  function automatic int n_full(input logic [1:0] l, input logic pe, input logic [1:0] st);
    return 1 + n_data(l) + (pe ? 1 : 0) + ((st == 2'b11) ? 2 : 1);
  endfunction

  function automatic int n_div(input logic [1:0] dv);
    if (dv == 2'b10) return 16;
    if (dv == 2'b11) return 64;
    return 1;
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input logic [1:0] l,
                                   input logic pe, input logic pev, input int idx);
    int nd, ones;
    nd = n_data(l);
    if (idx == 0) return 1'b0;
    if (idx <= nd) return d[idx-1];
    if (pe && idx == nd + 1) begin
      ones = 0;
      for (int i = 0; i < nd; i++) ones += int'(d[i]);
      return pev ? ((ones % 2) == 1) : ((ones % 2) == 0);
    end
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fall_pulse();
    @(negedge clk); txc_fall = 1'b1;
    @(negedge clk); txc_fall = 1'b0;
  endtask

  task automatic rise_pulse();
    @(negedge clk); txc_rise = 1'b1;
    @(negedge clk); txc_rise = 1'b0;
  endtask

  task automatic wr_char(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_cfg(input logic [15:0] v);
    cfg_len = v[7:6]; cfg_par_en = v[5]; cfg_par_even = v[4];
    cfg_stop = v[3:2]; cfg_div = v[1:0];
  endtask

  // write is already done; runs the whole frame and its end
  task automatic check_frame(input logic [15:0] v, input string tag);
    int nb, dv, err, bad_act;
    logic e;
    nb = n_full(v[7:6], v[5], v[3:2]);
    dv = n_div(v[1:0]);
    err = 0; bad_act = 0;
    for (int k = 0; k < nb * dv; k++) begin
      fall_pulse();
      e = exp_bit(v[15:8], v[7:6], v[5], v[4], k / dv);
      if (txd !== e) begin err++; bad_act = k; end
    end
    chk(err == 0, {tag, " frame bits R2 R3 R4 R6"}, err, 0);
    fall_pulse();
    if (v[3:2] == 2'b10) begin
      if (dv == 1) begin
        chk(tx_empty == 1'b0 && txd == 1'b1, {tag, " half stop held R5"}, int'(tx_empty), 0);
        rise_pulse();
      end else begin
        for (int h = 1; h < dv / 2; h++) fall_pulse();
        chk(tx_empty == 1'b0 && txd == 1'b1, {tag, " half stop length R5"}, int'(tx_empty), 0);
        fall_pulse();
      end
    end
    chk(tx_empty == 1'b1, {tag, " empty at frame end R9"}, int'(tx_empty), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] cfg8;
    rst = 1'b1; txc_fall = 1'b0; txc_rise = 1'b0; wr_en = 1'b0; wr_data = '0;
    tx_en = 1'b1; cts_n = 1'b0;
    set_cfg(16'h0001);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
    chk(tx_empty == 1'b1, "R1 empty", int'(tx_empty), 1);
    chk(tx_rdy == 1'b1, "R1 ready", int'(tx_rdy), 1);
    cts_n = 1'b1; #1;
    chk(tx_rdy == 1'b0, "R8 ready needs cts", int'(tx_rdy), 0);
    cts_n = 1'b0;

    // table walk
    for (int v = 0; v < 8; v++) begin
      set_cfg(VEC[v]);
      wr_char(VEC[v][15:8]);
      chk(tx_rdy == 1'b0 && tx_empty == 1'b0, "R8 R9 after write", int'(tx_rdy), 0);
      check_frame(VEC[v], $sformatf("vec%0d", v));
    end

    // R7 back-to-back through the holding register: 8 bits, no parity, 1 stop, x1
    cfg8 = 16'h00C1;
    set_cfg(cfg8);
    wr_char(8'h3C);
    fall_pulse();
    chk(txd == 1'b0, "R7 first start", int'(txd), 0);
    chk(tx_rdy == 1'b1, "R7 holding freed at start", int'(tx_rdy), 1);
    wr_char(8'hA9);
    chk(tx_rdy == 1'b0, "R8 busy hold", int'(tx_rdy), 0);
    begin
      int err = 0;
      for (int k = 1; k < 10; k++) begin
        fall_pulse();
        if (txd !== exp_bit(8'h3C, 2'b11, 1'b0, 1'b0, k)) err++;
      end
      chk(err == 0, "R7 first frame", err, 0);
    end
    fall_pulse();
    chk(txd == 1'b0 && tx_empty == 1'b0, "R7 no gap start", int'(txd), 0);
    begin
      int err = 0;
      for (int k = 1; k < 10; k++) begin
        fall_pulse();
        if (txd !== exp_bit(8'hA9, 2'b11, 1'b0, 1'b0, k)) err++;
      end
      chk(err == 0, "R7 second frame", err, 0);
    end
    fall_pulse();
    chk(tx_empty == 1'b1, "R9 empty after pair", int'(tx_empty), 1);

    // R10 gating
    @(negedge clk); cts_n = 1'b1;
    wr_char(8'h55);
    repeat (3) fall_pulse();
    chk(txd == 1'b1 && tx_empty == 1'b0, "R10 no start while cts high", int'(txd), 1);
    @(negedge clk); cts_n = 1'b0;
    fall_pulse();
    chk(txd == 1'b0, "R10 start after cts", int'(txd), 0);
    @(negedge clk); cts_n = 1'b1;
    wr_char(8'h0F);
    begin
      int err = 0;
      for (int k = 1; k < 10; k++) begin
        fall_pulse();
        if (txd !== exp_bit(8'h55, 2'b11, 1'b0, 1'b0, k)) err++;
      end
      chk(err == 0, "R10 frame completes after cts drop", err, 0);
    end
    fall_pulse();
    fall_pulse();
    chk(txd == 1'b1 && tx_empty == 1'b0, "R10 held char not started", int'(txd), 1);
    @(negedge clk); cts_n = 1'b0; tx_en = 1'b0;
    fall_pulse();
    chk(txd == 1'b1, "R10 no start with enable low", int'(txd), 1);
    @(negedge clk); tx_en = 1'b1;
    fall_pulse();
    chk(txd == 1'b0, "R10 start after enable", int'(txd), 0);
    begin
      int err = 0;
      for (int k = 1; k < 10; k++) begin
        fall_pulse();
        if (txd !== exp_bit(8'h0F, 2'b11, 1'b0, 1'b0, k)) err++;
      end
      chk(err == 0, "R10 resumed frame", err, 0);
    end
    fall_pulse();
    chk(tx_empty == 1'b1, "R9 empty after resume", int'(tx_empty), 1);

    // R11 config changed mid frame, R12 rise strobe has no effect
    set_cfg(16'h0001);
    wr_char(8'h1F);
    fall_pulse();
    @(negedge clk); set_cfg(16'h00FA);
    begin
      int err = 0;
      for (int k = 1; k < 7; k++) begin
        fall_pulse();
        if (txd !== exp_bit(8'h1F, 2'b00, 1'b0, 1'b0, k)) err++;
        if (k == 2) begin
          rise_pulse();
          chk(txd == exp_bit(8'h1F, 2'b00, 1'b0, 1'b0, 2), "R12 rise strobe no change",
              int'(txd), int'(exp_bit(8'h1F, 2'b00, 1'b0, 1'b0, 2)));
        end
      end
      chk(err == 0, "R11 frame keeps start config", err, 0);
    end
    fall_pulse();
    chk(tx_empty == 1'b1, "R11 frame length kept", int'(tx_empty), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule